// File: doc/BRIEF.md
# Receive Frame Length Supervisor

This block watches the bytes of an incoming frame as a deframer stores them into a receive buffer. It keeps a running count of the stored bytes and compares it against a programmable ceiling. When the frame grows past that ceiling, reception is cut short. The block then reports the event on the same outputs as a frame that the far end aborted: an end-of-message interrupt pulse and the aborted status bit.

The ceiling is given in units of 32 bytes. A 7-bit length code `len_code` selects a ceiling of `(len_code + 1) * 32` bytes. Address bytes that are flagged by the deframer are not counted. The status byte that closes every frame is counted. As a result, software can tell a length overrun from a genuine remote abort: after an overrun, the reported count is one or two above the ceiling. When the check is switched off, the counter keeps running and frames end only through their own end event.

Top module: `rx_len_supervisor`

## Requirements
- R1: After reset, `byte_cnt` is 0 and `term_rx`, `rme_irq` and `rx_aborted` are 0.
- R2: The count rises by one for each `byte_wr` with `byte_is_addr` = 0 and for each accepted `stat_wr`. A `byte_wr` with `byte_is_addr` = 1 leaves it unchanged. A `sof` cycle clears it to 0, and any write in that same cycle is ignored.
- R3: Let LIMIT = (`len_code` + 1) * 32 with `chk_en` = 1. The clock edge that takes in the write making the count exceed LIMIT raises `term_rx` and `rme_irq` for exactly one cycle and sets `rx_aborted`. At that point `byte_cnt` reads LIMIT + 1.
- R4: After a termination and until the next `sof`, data writes and `eof` are ignored: the count does not move and no `rme_irq` pulse occurs. Exactly one `stat_wr` is still counted, which brings `byte_cnt` to LIMIT + 2. Further status writes are ignored.
- R5: With `chk_en` = 0, no termination occurs. The count saturates at 2^CNT_W - 1 (8191 by default) instead of wrapping.
- R6: An `eof` outside a terminated frame gives one `rme_irq` pulse on the next edge. It sets `rx_aborted` to the value of `eof_abort`: 0 for a normal end, 1 for a remote abort.
- R7: A `sof` clears `rx_aborted`.
- R8: A frame of exactly LIMIT counted bytes is never terminated.
- R9: If the overrunning write and `eof` arrive in the same cycle, a single `rme_irq` pulse results and `rx_aborted` is 1, even if `eof_abort` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Length check enable |
| len_code | input | 7 | Ceiling code, ceiling = (code+1)*32 bytes |
| byte_wr | input | 1 | A frame byte is written to the receive buffer |
| byte_is_addr | input | 1 | The byte written this cycle is an address byte |
| sof | input | 1 | Start of a new frame |
| eof | input | 1 | End of the current frame |
| eof_abort | input | 1 | Qualifies `eof` as a remote abort |
| stat_wr | input | 1 | The frame status byte is written |
| term_rx | output | 1 | One-cycle pulse ending an over-long reception |
| rme_irq | output | 1 | One-cycle end-of-message interrupt pulse |
| rx_aborted | output | 1 | Aborted status of the last frame |
| byte_cnt | output | 13 | Running receive byte count |

## Verification
The overrun termination and the ordinary end-of-frame report can fall on the same clock edge. They drive the same interrupt and status bit. The bench provokes this by filling a frame to exactly the ceiling and then raising the next data write together with a normal `eof`. It expects a single interrupt pulse, the aborted bit set and the count at ceiling plus one. On the following cycle, it expects no second pulse.

// File: rtl/rxls_pkg.sv
package rxls_pkg;

  // Which writes of this cycle the counter takes in
  typedef struct packed {
    logic data;
    logic stat;
  } rxls_acc_t;

  localparam int unsigned RXLS_BLK_SH = 5;  // ceiling granule is 2**5 bytes

endpackage

// File: rtl/rxls_counter.sv
module rxls_counter
  import rxls_pkg::*;
#(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  rxls_acc_t        acc,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]     inc;
  logic [CNT_W:0] sum;
  logic           cnt_en;

  always_comb begin
    inc    = {1'b0, acc.data} + {1'b0, acc.stat};
    sum    = {1'b0, cnt} + {{(CNT_W-1){1'b0}}, inc};
    cnt_en = clr | (inc != 2'd0);
    if (clr)
      cnt_nxt = '0;
    else if (sum[CNT_W])
      cnt_nxt = CNT_MAX;
    else
      cnt_nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt_en)
      cnt <= cnt_nxt;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (cnt >= $past(cnt))) else $error("count wrapped"); // R5

endmodule

// File: rtl/rxls_limit_cmp.sv
module rxls_limit_cmp
  import rxls_pkg::*;
#(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned CNT_W  = 13
) (
  input  logic [CODE_W-1:0] len_code,
  input  logic [CNT_W-1:0]  cnt_nxt,
  output logic [CNT_W-1:0]  limit,
  output logic              over
);

  localparam int unsigned PAD_W = CNT_W - CODE_W - 1;

  logic [CODE_W:0] blocks;

  always_comb begin
    blocks = {1'b0, len_code} + {{CODE_W{1'b0}}, 1'b1};
    limit  = {{PAD_W{1'b0}}, blocks} << RXLS_BLK_SH;
    over   = cnt_nxt > limit;
  end

endmodule

// File: rtl/rxls_frame_ctl.sv
module rxls_frame_ctl
  import rxls_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chk_en,
  input  logic      sof,
  input  logic      eof,
  input  logic      eof_abort,
  input  logic      byte_wr,
  input  logic      byte_is_addr,
  input  logic      stat_wr,
  input  logic      over,
  output rxls_acc_t acc,
  output logic      clr,
  output logic      term_q,
  output logic      rme_q,
  output logic      rab_q
);

  logic discard_q, discard_d;
  logic post_stat_q, post_stat_d;
  logic rab_d, rab_en;
  logic hit, eof_ok;

  always_comb begin
    clr         = sof;
    acc.data    = ~sof & ~discard_q & byte_wr & ~byte_is_addr;
    acc.stat    = ~sof & stat_wr & (~discard_q | ~post_stat_q);
    hit         = ~sof & ~discard_q & chk_en & over;
    eof_ok      = ~sof & ~discard_q & eof & ~hit;
    discard_d   = ~sof & (discard_q | hit);
    post_stat_d = ~sof & (post_stat_q | (discard_q & stat_wr));
    rab_en      = sof | hit | eof_ok;
    if (sof)
      rab_d = 1'b0;
    else if (hit)
      rab_d = 1'b1;
    else
      rab_d = eof_abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      discard_q   <= 1'b0;
      post_stat_q <= 1'b0;
      term_q      <= 1'b0;
      rme_q       <= 1'b0;
    end else begin
      discard_q   <= discard_d;
      post_stat_q <= post_stat_d;
      term_q      <= hit;
      rme_q       <= hit | eof_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rab_q <= 1'b0;
    else if (rab_en)
      rab_q <= rab_d;
  end

  AST_TERM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    term_q |=> !term_q) else $error("termination longer than one cycle"); // R3
  AST_TERM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    term_q |-> $past(chk_en)) else $error("termination while disabled"); // R5
  AST_SOF_CLR_RAB: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !rab_q) else $error("aborted bit survived frame start"); // R7
  AST_QUIET_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_q && !sof) |=> !rme_q) else $error("interrupt after termination"); // R4

endmodule

// File: rtl/rx_len_supervisor.sv
module rx_len_supervisor
  import rxls_pkg::*;
#(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic [CODE_W-1:0] len_code,
  input  logic              byte_wr,
  input  logic              byte_is_addr,
  input  logic              sof,
  input  logic              eof,
  input  logic              eof_abort,
  input  logic              stat_wr,
  output logic              term_rx,
  output logic              rme_irq,
  output logic              rx_aborted,
  output logic [CNT_W-1:0]  byte_cnt
);

  rxls_acc_t        acc;
  logic             clr;
  logic             over;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] limit;

  rxls_frame_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_en       (chk_en),
    .sof          (sof),
    .eof          (eof),
    .eof_abort    (eof_abort),
    .byte_wr      (byte_wr),
    .byte_is_addr (byte_is_addr),
    .stat_wr      (stat_wr),
    .over         (over),
    .acc          (acc),
    .clr          (clr),
    .term_q       (term_rx),
    .rme_q        (rme_irq),
    .rab_q        (rx_aborted)
  );

  rxls_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .acc     (acc),
    .cnt_nxt (cnt_nxt),
    .cnt     (byte_cnt)
  );

  rxls_limit_cmp #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_lim (
    .len_code (len_code),
    .cnt_nxt  (cnt_nxt),
    .limit    (limit),
    .over     (over)
  );

  AST_TERM_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    term_rx |-> (byte_cnt == $past(limit) + 1'b1)) else $error("bad overshoot"); // R3
  AST_TERM_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    term_rx |-> (rme_irq && rx_aborted)) else $error("overrun not reported as abort"); // R9

endmodule

// File: tb/rx_len_supervisor_tb.sv
module rx_len_supervisor_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_en, byte_wr, byte_is_addr, sof, eof, eof_abort, stat_wr;
  logic [6:0]  len_code;
  logic        term_rx, rme_irq, rx_aborted;
  logic [12:0] byte_cnt;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rx_len_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .len_code(len_code),
    .byte_wr(byte_wr), .byte_is_addr(byte_is_addr), .sof(sof), .eof(eof),
    .eof_abort(eof_abort), .stat_wr(stat_wr), .term_rx(term_rx),
    .rme_irq(rme_irq), .rx_aborted(rx_aborted), .byte_cnt(byte_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Apply one cycle of strobes, then sample 2 ns after the edge
  task automatic cyc(input bit w, input bit a, input bit s, input bit e,
                     input bit ea, input bit st);
    byte_wr = w; byte_is_addr = a; sof = s; eof = e; eof_abort = ea; stat_wr = st;
    @(posedge clk);
    #2;
    byte_wr = 0; byte_is_addr = 0; sof = 0; eof = 0; eof_abort = 0; stat_wr = 0;
  endtask

  task automatic sweep_code(input int code);
    int lim = (code + 1) * 32;
    len_code = code[6:0];
    chk_en   = 1'b1;
    cyc(0, 0, 1, 0, 0, 0);
    chk("R7 rab after sof", rx_aborted, 0);
    chk("R2 clear on sof", byte_cnt, 0);
    cyc(1, 1, 0, 0, 0, 0);  // address byte
    chk("R2 address not counted", byte_cnt, 0);
    for (int i = 1; i <= lim + 3; i++) begin
      cyc(1, 0, 0, 0, 0, 0);
      if (i <= lim) begin
        chk("R2 data count", byte_cnt, i);
        if (i == lim) chk("R8 no term at limit", term_rx, 0);
      end else begin
        chk("R3/R4 count frozen", byte_cnt, lim + 1);
        chk("R3 term pulse", term_rx, (i == lim + 1) ? 1 : 0);
        chk("R3 rme pulse", rme_irq, (i == lim + 1) ? 1 : 0);
        chk("R3 aborted", rx_aborted, 1);
      end
    end
    cyc(0, 0, 0, 1, 0, 0);
    chk("R4 eof ignored", rme_irq, 0);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R4 status counted", byte_cnt, lim + 2);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R4 second status ignored", byte_cnt, lim + 2);
  endtask

  initial begin
    rst_n = 0; chk_en = 0; len_code = 0;
    byte_wr = 0; byte_is_addr = 0; sof = 0; eof = 0; eof_abort = 0; stat_wr = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 cnt", byte_cnt, 0);
    chk("R1 term", term_rx, 0);
    chk("R1 rme", rme_irq, 0);
    chk("R1 rab", rx_aborted, 0);
    rst_n = 1;
    @(posedge clk); #2;

    for (int c = 0; c < 8; c++) sweep_code(c);
    for (int c = 124; c < 128; c++) sweep_code(c);

    // R6 normal end at exactly the limit, then remote abort
    len_code = 0; chk_en = 1;
    cyc(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 31; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R8 status at limit", byte_cnt, 32);
    chk("R8 no term", term_rx, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 rme normal", rme_irq, 1);
    chk("R6 rab normal", rx_aborted, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R6 rme one cycle", rme_irq, 0);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(1, 0, 0, 1, 1, 0);
    chk("R6 rme remote abort", rme_irq, 1);
    chk("R6 rab remote abort", rx_aborted, 1);
    chk("R2 byte with eof", byte_cnt, 1);
    cyc(1, 0, 1, 0, 0, 0);
    chk("R7 sof clears rab", rx_aborted, 0);
    chk("R2 sof-cycle write ignored", byte_cnt, 0);

    // R9 overrun and end event in the same cycle
    for (int i = 0; i < 32; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 1, 0, 0);
    chk("R9 term", term_rx, 1);
    chk("R9 rme", rme_irq, 1);
    chk("R9 rab", rx_aborted, 1);
    chk("R9 cnt", byte_cnt, 33);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R9 single rme", rme_irq, 0);

    // R5 check disabled: no termination, saturation
    chk_en = 0; len_code = 0;
    cyc(0, 0, 1, 0, 0, 0);
    for (int i = 1; i <= 8195; i++) begin
      cyc(1, 0, 0, 0, 0, 0);
      if (term_rx) chk("R5 no term when disabled", 1, 0);
    end
    chk("R5 saturate", byte_cnt, 8191);
    chk("R5 rab clear", rx_aborted, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule